// File: doc/BRIEF.md
# Page-Bounded DMA Transfer Engine

This block copies a block of bytes between a device stream and memory without the processor taking part. Software sets up four values: a device address, a memory start address, a byte count, and a direction. It then sets a start bit. The engine requests the shared memory bus and moves one 32-bit word for each granted access. It raises a sticky completion flag when the whole request has been moved.

Memory addresses are physical, so no burst may cross a page boundary. The engine splits a long request into segments. Each segment runs from the current address up to the next page boundary, or up to the end of the request if that comes first. Between segments the engine drops its bus request so that the processor can win arbitration. The segments run back to back and the completion flag is raised only after the last one.

The controller is a five-state machine:

- **IDLE**: waiting for a start.
- **LOAD**: computes the next segment length; the bus request is low.
- **MEM**: requests the bus and makes one word access once granted.
- **DEV**: one handshake on the device stream; the bus request stays held.
- **GAP**: releases the bus.

The transitions are:

- **start** (IDLE to LOAD): an aligned request with a nonzero count.
- **first** (LOAD to MEM when reading memory, LOAD to DEV when writing memory).
- **access** (MEM to DEV, or MEM to GAP on the last word of a segment when writing memory).
- **handshake** (DEV to MEM, or DEV to GAP on the last word of a segment when reading memory).
- **chain** (GAP to LOAD while bytes remain).
- **finish** (GAP to IDLE).

Top module: `pgdma_engine`

## Requirements
- R1: After reset, busy, err, irq, bus_req, mem_en, tx_valid and rx_ready are all low.
- R2: Setup writes use cfg_sel to pick a register: 0 = device address (driven on dev_addr), 1 = memory start address, 2 = byte count, 3 = control. The control register has these bits: bit0 start; bit1 direction (1 = memory to device, 0 = device to memory); bit2 write-1-to-clear of irq; bit3 write-1-to-clear of err.
- R3: A memory access (mem_en) happens only while bus_req and bus_gnt are both high. Each access moves one 32-bit word. Successive accesses use ascending addresses 4 bytes apart, starting at the programmed address. Read data is taken from mem_rdata in the cycle of the access.
- R4: Each segment is the smaller of the remaining bytes and the bytes left before the next page boundary (page = PAGE_BYTES, default 4096). All accesses made under one bus_req assertion fall inside one page.
- R5: bus_req goes low for at least one cycle between segments. The number of bus_req assertions in a transfer equals the number of segments.
- R6: In the memory-to-device direction, memory words are presented on tx_data in address order, one per tx_valid/tx_ready handshake. In the device-to-memory direction, words taken by rx_valid/rx_ready handshakes are written to memory in arrival order.
- R7: irq rises only once the last segment completes, never while busy is high. It stays high until control bit2 is written with 1.
- R8: A start with a memory address or byte count whose low two bits are not zero sets err, and no transfer takes place: busy stays low and bus_req is never raised. Writing 1 to control bit2 leaves err set; writing 1 to control bit3 clears it.
- R9: While busy is high, writes to the device address, memory address and count registers are ignored, and so is a start write.
- R10: A start with a byte count of zero sets irq at once, with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 2 | Setup register select |
| cfg_wdata | input | 32 | Setup write data |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky misalignment error |
| irq | output | 1 | Sticky completion interrupt |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the access cycle |
| dev_addr | output | DEV_W | Programmed device address |
| tx_valid | output | 1 | Word offered to device |
| tx_ready | input | 1 | Device accepts word |
| tx_data | output | 32 | Word to device |
| rx_valid | input | 1 | Device offers word |
| rx_ready | output | 1 | Engine accepts word |
| rx_data | input | 32 | Word from device |

## Verification
The engine is exercised with four request shapes:

- A short read inside one page shows basic ordering and the single-segment case.
- A device-to-memory write across one boundary separates correct two-way splitting from a burst that runs over the page.
- A three-segment read, with grant and device-ready stalls, tells apart a split computed from the page offset and one computed from the count alone. It also shows that stalls do not lose or repeat words.
- Misaligned, zero-count and busy-time writes show that rejected or late setup leaves memory, the stream and the flags untouched.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MEM,
        ST_DEV,
        ST_GAP
    } dma_state_t;

    localparam logic [1:0] SEL_DEV  = 2'd0;
    localparam logic [1:0] SEL_MEM  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTL  = 2'd3;

    localparam int CTL_START   = 0;
    localparam int CTL_DIR     = 1;
    localparam int CTL_CLR_IRQ = 2;
    localparam int CTL_CLR_ERR = 3;

    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/pgdma_regs.sv
module pgdma_regs
    import pgdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              busy,
    output logic [DEV_W-1:0]  dev_q,
    output logic [ADDR_W-1:0] maddr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              to_dev_q,
    output logic              start_p,
    output logic              clr_irq,
    output logic              clr_err
);
    logic wr_ctl;
    logic cfg_unused;

    assign cfg_unused = ^cfg_wdata;
    assign wr_ctl  = cfg_we && (cfg_sel == SEL_CTL);
    assign start_p = wr_ctl && cfg_wdata[CTL_START] && !busy;
    assign clr_irq = wr_ctl && cfg_wdata[CTL_CLR_IRQ];
    assign clr_err = wr_ctl && cfg_wdata[CTL_CLR_ERR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q    <= '0;
            maddr_q  <= '0;
            cnt_q    <= '0;
            to_dev_q <= 1'b0;
        end else if (cfg_we && !busy) begin
            unique case (cfg_sel)
                SEL_DEV: dev_q   <= cfg_wdata[DEV_W-1:0];
                SEL_MEM: maddr_q <= cfg_wdata[ADDR_W-1:0];
                SEL_CNT: cnt_q   <= cfg_wdata[CNT_W-1:0];
                SEL_CTL: if (cfg_wdata[CTL_START]) to_dev_q <= cfg_wdata[CTL_DIR];
                default: ;
            endcase
        end
    end

    AST_SETUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we && cfg_sel != SEL_CTL) |=> ($stable(dev_q) && $stable(maddr_q) && $stable(cnt_q))); // R9
endmodule

// File: rtl/pgdma_seg_calc.sv
module pgdma_seg_calc #(
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [$clog2(PAGE_BYTES)-1:0] addr_off,
    input  logic [CNT_W-1:0]              remain,
    output logic [CNT_W-1:0]              seg_len
);
    localparam int PAGE_LOG2 = $clog2(PAGE_BYTES);
    localparam int CW = (CNT_W > PAGE_LOG2 + 1) ? CNT_W : PAGE_LOG2 + 1;

    logic [CW-1:0] room;
    logic [CW-1:0] rem_w;
    logic [CW-1:0] pick;

    assign room    = CW'(PAGE_BYTES) - CW'(addr_off);
    assign rem_w   = CW'(remain);
    assign pick    = (rem_w < room) ? rem_w : room;
    assign seg_len = CNT_W'(pick);
endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine
    import pgdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DEV_W      = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              busy,
    output logic              err,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [31:0]       rx_data
);
    localparam int PAGE_LOG2 = $clog2(PAGE_BYTES);
    localparam int PN_W      = ADDR_W - PAGE_LOG2;

    dma_state_t        state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  rem_q, seg_q, seg_len;
    logic [PN_W-1:0]   seg_page_q;
    logic [31:0]       buf_q;
    logic              irq_q, err_q;

    logic [ADDR_W-1:0] maddr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              to_dev_q, start_p, clr_irq, clr_err;
    logic              misal, access, dev_hs;

    pgdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .dev_q(dev_addr),
        .maddr_q(maddr_q), .cnt_q(cnt_q), .to_dev_q(to_dev_q),
        .start_p(start_p), .clr_irq(clr_irq), .clr_err(clr_err)
    );

    pgdma_seg_calc #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) seg_i (
        .addr_off(cur_addr_q[PAGE_LOG2-1:0]), .remain(rem_q), .seg_len(seg_len)
    );

    assign misal  = (|maddr_q[1:0]) || (|cnt_q[1:0]);
    assign access = (state_q == ST_MEM) && bus_gnt;
    assign dev_hs = (tx_valid && tx_ready) || (rx_valid && rx_ready);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_p && !misal && cnt_q != '0) state_d = ST_LOAD;
            ST_LOAD: state_d = to_dev_q ? ST_MEM : ST_DEV;
            ST_MEM:  if (bus_gnt) begin
                         if (!to_dev_q && seg_q == CNT_W'(WORD_BYTES)) state_d = ST_GAP;
                         else                                           state_d = to_dev_q ? ST_DEV : ST_MEM;
                         if (!to_dev_q && seg_q != CNT_W'(WORD_BYTES)) state_d = ST_DEV;
                     end
            ST_DEV:  if (dev_hs) begin
                         if (to_dev_q && seg_q == '0) state_d = ST_GAP;
                         else                         state_d = ST_MEM;
                     end
            ST_GAP:  state_d = (rem_q == '0) ? ST_IDLE : ST_LOAD;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            rem_q      <= '0;
            seg_q      <= '0;
            seg_page_q <= '0;
            buf_q      <= '0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (clr_irq) irq_q <= 1'b0;
            if (clr_err) err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_p) begin
                    if (misal)              err_q <= 1'b1;
                    else if (cnt_q == '0)   irq_q <= 1'b1;
                    else begin
                        cur_addr_q <= maddr_q;
                        rem_q      <= cnt_q;
                    end
                end
                ST_LOAD: begin
                    seg_q      <= seg_len;
                    seg_page_q <= cur_addr_q[ADDR_W-1:PAGE_LOG2];
                end
                ST_MEM: if (bus_gnt) begin
                    cur_addr_q <= cur_addr_q + ADDR_W'(WORD_BYTES);
                    rem_q      <= rem_q - CNT_W'(WORD_BYTES);
                    seg_q      <= seg_q - CNT_W'(WORD_BYTES);
                    if (to_dev_q) buf_q <= mem_rdata;
                end
                ST_DEV: if (rx_valid && rx_ready) buf_q <= rx_data;
                ST_GAP: if (rem_q == '0) irq_q <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        irq       = irq_q;
        err       = err_q;
        bus_req   = (state_q == ST_MEM) || (state_q == ST_DEV);
        mem_en    = access;
        mem_we    = access && !to_dev_q;
        mem_addr  = cur_addr_q;
        mem_wdata = buf_q;
        tx_valid  = (state_q == ST_DEV) && to_dev_q;
        tx_data   = buf_q;
        rx_ready  = (state_q == ST_DEV) && !to_dev_q;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (cur_addr_q == $past(mem_addr) + ADDR_W'(WORD_BYTES))); // R3
    AST_PAGE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[ADDR_W-1:PAGE_LOG2] == seg_page_q)); // R4
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(bus_req)) |=> !bus_req); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq); // R7
    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy); // R7
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !bus_req)); // R8
endmodule

// File: tb/pgdma_engine_tb.sv
`timescale 1ns/1ps
module pgdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        busy, err, irq, bus_req, mem_en, mem_we;
    logic        bus_gnt = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, tx_data, rx_data;
    logic [15:0] dev_addr;
    logic        tx_valid, rx_ready;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;

    int pass_cnt = 0;
    int fail_cnt = 0;
    int cyc = 0;
    bit stall = 1'b0;

    logic [31:0] mem [0:4095];
    logic [31:0] tx_log [0:2047];
    int  tx_cnt = 0;
    int  rx_idx = 0;
    logic [31:0] rx_base = 32'h0;
    int  seg_cnt = 0, page_err = 0, addr_err = 0, acc_cnt = 0, irq_busy = 0;
    logic [31:0] exp_addr = 32'h0;
    logic [31:0] seg_page = 32'h0;
    bit  seg_first = 1'b0;
    bit  req_prev = 1'b0;

    always #10 clk = ~clk;

    pgdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .err(err), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_addr(dev_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data)
    );

    assign mem_rdata = mem[mem_addr[13:2]];
    assign rx_data   = rx_base + 32'(rx_idx);

    function automatic logic [31:0] init_word(input int idx);
        return 32'hA500_0000 + 32'(idx);
    endfunction

    always @(negedge clk) begin
        cyc++;
        bus_gnt  = bus_req && (!stall || cyc[0]);
        tx_ready = !stall || cyc[1];
        rx_valid = !stall || (cyc % 3 != 0);
    end

    always @(posedge clk) begin
        if (bus_req && !req_prev) begin
            seg_cnt++;
            seg_first = 1'b1;
        end
        if (mem_en) begin
            if (seg_first) begin
                seg_page  = mem_addr >> 12;
                seg_first = 1'b0;
            end else if ((mem_addr >> 12) != seg_page) page_err++;
            if (mem_addr != exp_addr || !bus_gnt || !bus_req) addr_err++;
            exp_addr = exp_addr + 32'd4;
            acc_cnt++;
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        end
        if (irq && busy) irq_busy++;
        if (tx_valid && tx_ready) begin
            tx_log[tx_cnt] = tx_data;
            tx_cnt++;
        end
        if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
        req_prev = bus_req;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_mon(input logic [31:0] a);
        seg_cnt = 0; page_err = 0; addr_err = 0; acc_cnt = 0; irq_busy = 0;
        tx_cnt = 0; exp_addr = a;
    endtask

    task automatic start_xfer(input logic [15:0] dv, input logic [31:0] a, input logic [31:0] n, input bit to_dev);
        clear_mon(a);
        cfg_write(2'd0, {16'h0, dv});
        cfg_write(2'd1, a);
        cfg_write(2'd2, n);
        cfg_write(2'd3, {30'h0, to_dev, 1'b1});
    endtask

    task automatic wait_idle(input int limit);
        int n = 0;
        while (busy && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (busy) chk(1'b0, "timeout", 32'(n), 32'(limit));
    endtask

    task automatic tx_mismatch(input int base_idx, input int n, output int bad);
        bad = 0;
        for (int k = 0; k < n; k++)
            if (tx_log[k] != init_word(base_idx + k)) bad++;
    endtask

    task automatic t_reset;
        chk(!busy && !err && !irq && !bus_req && !mem_en && !tx_valid && !rx_ready,
            "R1 reset outputs", {26'h0, busy, err, irq, bus_req, tx_valid, rx_ready}, 32'h0);
    endtask

    task automatic t_read_in_page;
        int bad;
        start_xfer(16'h55AA, 32'h100, 32'd32, 1'b1);
        chk(dev_addr == 16'h55AA, "R2 dev_addr", {16'h0, dev_addr}, 32'h55AA);
        chk(busy, "R2 start sets busy", {31'h0, busy}, 32'h1);
        wait_idle(2000);
        tx_mismatch(32'h100 >> 2, 8, bad);
        chk(tx_cnt == 8 && bad == 0, "R6 read words in order", 32'(tx_cnt), 32'd8);
        chk(seg_cnt == 1, "R4 single segment", 32'(seg_cnt), 32'd1);
        chk(addr_err == 0 && acc_cnt == 8, "R3 ascending granted accesses", 32'(addr_err), 32'd0);
        repeat (5) @(negedge clk);
        chk(irq && irq_busy == 0, "R7 irq sticky after finish", {31'h0, irq}, 32'h1);
        cfg_write(2'd3, 32'h4);
        chk(!irq, "R7 irq cleared by bit2", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_write_cross;
        int bad = 0;
        rx_base = 32'hC0DE_0000;
        rx_idx  = 0;
        start_xfer(16'h0003, 32'h0FF8, 32'd16, 1'b0);
        wait_idle(2000);
        for (int k = 0; k < 4; k++)
            if (mem[(32'h0FF8 >> 2) + k] != rx_base + 32'(k)) bad++;
        chk(bad == 0, "R6 device words written in order", 32'(bad), 32'd0);
        chk(seg_cnt == 2, "R5 two bus requests across boundary", 32'(seg_cnt), 32'd2);
        chk(page_err == 0, "R4 no page crossing in write", 32'(page_err), 32'd0);
        chk(acc_cnt == 4 && addr_err == 0, "R3 write access count", 32'(acc_cnt), 32'd4);
        chk(irq, "R7 irq after chain", {31'h0, irq}, 32'h1);
        cfg_write(2'd3, 32'h4);
    endtask

    task automatic t_multi_stall;
        int bad;
        stall = 1'b1;
        start_xfer(16'h0009, 32'h1FF0, 32'h1020, 1'b1);
        wait_idle(20000);
        stall = 1'b0;
        tx_mismatch(32'h1FF0 >> 2, 1032, bad);
        chk(tx_cnt == 1032 && bad == 0, "R6 stalled read data", 32'(tx_cnt), 32'd1032);
        chk(seg_cnt == 3, "R5 three segments", 32'(seg_cnt), 32'd3);
        chk(page_err == 0, "R4 segments stay in page", 32'(page_err), 32'd0);
        chk(addr_err == 0, "R3 stalled accesses granted and ascending", 32'(addr_err), 32'd0);
        chk(irq && irq_busy == 0, "R7 irq only at end", 32'(irq_busy), 32'd0);
        cfg_write(2'd3, 32'h4);
    endtask

    task automatic t_misaligned;
        start_xfer(16'h0001, 32'h102, 32'd8, 1'b1);
        chk(err && !busy && !irq, "R8 misaligned address flags err", {30'h0, err, busy}, 32'h2);
        repeat (4) @(negedge clk);
        chk(seg_cnt == 0 && tx_cnt == 0, "R8 no bus activity", 32'(seg_cnt), 32'd0);
        cfg_write(2'd3, 32'h4);
        chk(err, "R8 bit2 leaves err set", {31'h0, err}, 32'h1);
        cfg_write(2'd3, 32'h8);
        chk(!err, "R8 err cleared by bit3", {31'h0, err}, 32'h0);
        start_xfer(16'h0001, 32'h100, 32'd6, 1'b1);
        chk(err && !busy && seg_cnt == 0, "R8 misaligned count flags err", {31'h0, err}, 32'h1);
        cfg_write(2'd3, 32'h8);
    endtask

    task automatic t_zero;
        start_xfer(16'h0002, 32'h200, 32'd0, 1'b1);
        chk(irq && !busy, "R10 zero count completes at once", {31'h0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        chk(seg_cnt == 0, "R10 no bus request", 32'(seg_cnt), 32'd0);
        cfg_write(2'd3, 32'h4);
    endtask

    task automatic t_busy_ignore;
        int bad;
        start_xfer(16'h0004, 32'h400, 32'd64, 1'b1);
        cfg_write(2'd1, 32'h800);
        cfg_write(2'd2, 32'd4);
        cfg_write(2'd3, 32'h1);
        wait_idle(2000);
        tx_mismatch(32'h400 >> 2, 16, bad);
        chk(tx_cnt == 16 && bad == 0 && addr_err == 0, "R9 busy writes ignored", 32'(tx_cnt), 32'd16);
        cfg_write(2'd3, 32'h4);
        clear_mon(32'h400);
        cfg_write(2'd3, 32'h3);
        wait_idle(2000);
        tx_mismatch(32'h400 >> 2, 16, bad);
        chk(tx_cnt == 16 && bad == 0 && addr_err == 0, "R9 setup kept after busy writes", 32'(tx_cnt), 32'd16);
        cfg_write(2'd3, 32'h4);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_in_page();
        t_write_cross();
        t_multi_stall();
        t_misaligned();
        t_zero();
        t_busy_ignore();
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fail_cnt++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end
endmodule